// File: doc/BRIEF.md
# Programmable Logarithmic Shifter

This block shifts a W-bit word (8 bits by default) in a single combinational pass. Three controls set what it does. A binary shift count of log2(W) bits gives the distance. A direction flag chooses left or right. A two-bit kind field chooses logical, arithmetic or circular shifting. The result appears on the output in the same cycle. No register lies between input and output.

The count is never decoded into one-hot select lines. The datapath is a cascade of log2(W) stages. Stage i is driven straight from bit i of the count: it moves its input by 2^i positions when that bit is 1 and passes it through unchanged when the bit is 0. The distances of the enabled stages add up to the requested amount. A small control decoder turns the kind and direction into one fill policy that every stage shares. The policy is one of three:
- zero fill;
- sign fill;
- wrap, where bits that leave one end come back in at the other.

Top module: `logshift_unit`

## Requirements
- R1: With a shift count of 0 the output equals the input for every kind and direction.
- R2: A logical left shift (kind 2'b00, `shift_left`=1) by k gives the input moved k places toward the MSB, with the k vacated low bits set to 0.
- R3: A logical right shift (kind 2'b00, `shift_left`=0) by k gives the input moved k places toward the LSB, with the k vacated high bits set to 0.
- R4: An arithmetic right shift (kind 2'b01, `shift_left`=0) by k fills the k vacated high bits with the input's MSB.
- R5: An arithmetic left shift (kind 2'b01, `shift_left`=1) gives the same result as a logical left shift.
- R6: A circular shift (kind 2'b10) rotates the word: bits leaving one end re-enter at the other, so the number of ones is unchanged.
- R7: The reserved kind 2'b11 behaves exactly as logical (2'b00) in both directions.
- R8: The count is plain binary of log2(W) bits, and bit i enables a move of 2^i. Any count from 0 to W-1 gives a total shift equal to its value, including multi-bit counts such as 7.
- R9: `shift_left`=1 selects the move toward the MSB and `shift_left`=0 selects the move toward the LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | W | Word to be shifted |
| shift_amt | input | log2(W) | Binary shift distance, 0 to W-1 |
| shift_left | input | 1 | 1 = toward MSB, 0 = toward LSB |
| shift_kind | input | 2 | 00 logical, 01 arithmetic, 10 circular, 11 treated as logical |
| data_out | output | W | Shifted word |

## Verification
The stage assertions assume that the control word from the decoder changes in one step as a whole. They also assume that each stage's data input may come from any earlier stage state. For that reason every assertion relates only a stage's own input, its enable and its shared control, and holds for any data value. The assertions further assume that W is a power of two, so each stage distance is below W. The stimulus keeps within these limits: it sweeps every data byte, every count from 0 to W-1, both directions and all four kind codes. All inputs change together once per cycle, and results are read at the opposite clock edge against a behavioural model that shifts one bit at a time.

// File: rtl/logshift_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the logarithmic shifter.
// Assumes nothing beyond IEEE 1800-2017 enum/struct support.
package logshift_pkg;

    // Encoding of the external kind field (2'b11 is reserved, acts as logical).
    typedef enum logic [1:0] {
        KIND_LOGICAL  = 2'b00,
        KIND_ARITH    = 2'b01,
        KIND_CIRCULAR = 2'b10,
        KIND_RESERVED = 2'b11
    } shift_kind_e;

    // Fill policy shared by every stage.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_mode_e;

    // Control word broadcast to all stages; kept in one struct so it updates atomically.
    typedef struct packed {
        logic       to_msb;
        fill_mode_e mode;
    } stage_ctrl_t;

endpackage

// File: rtl/logshift_ctrl.sv
`timescale 1ns/1ps
// Module: logshift_ctrl
// Turns the external kind code and direction into one fill policy plus
// direction for all stages. Assumes the kind code follows logshift_pkg.
module logshift_ctrl
    import logshift_pkg::*;
(
    input  logic [1:0]  kind,
    input  logic        to_msb,
    output stage_ctrl_t ctrl
);

    // Select the fill policy: wrap for circular, sign only for arithmetic right, else zero.
    always_comb begin
        ctrl.to_msb = to_msb;
        ctrl.mode   = FILL_ZERO;
        if (kind == KIND_CIRCULAR) begin
            ctrl.mode = FILL_WRAP;
        end else if (kind == KIND_ARITH && !to_msb) begin
            ctrl.mode = FILL_SIGN;
        end
    end

endmodule

// File: rtl/logshift_stage.sv
`timescale 1ns/1ps
// Module: logshift_stage
// One power-of-two stage: moves its input by DIST places when en is set,
// otherwise passes it through. Assumes 0 < DIST < W.
module logshift_stage
    import logshift_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  stage_ctrl_t  ctrl,
    output logic [W-1:0] dout
);

    localparam int BACK = W - DIST;

    logic [W-1:0] up_zero;
    logic [W-1:0] up_wrap;
    logic [W-1:0] dn_zero;
    logic [W-1:0] dn_sign;
    logic [W-1:0] dn_wrap;

    // Form every candidate move, pick one, then check it against this stage's own inputs.
    always_comb begin
        up_zero = din << DIST;
        up_wrap = (din << DIST) | (din >> BACK);
        dn_zero = din >> DIST;
        dn_sign = W'($signed(din) >>> DIST);
        dn_wrap = (din >> DIST) | (din << BACK);

        if (!en) begin
            dout = din;
        end else if (ctrl.to_msb) begin
            dout = (ctrl.mode == FILL_WRAP) ? up_wrap : up_zero;
        end else begin
            case (ctrl.mode)
                FILL_WRAP: dout = dn_wrap;
                FILL_SIGN: dout = dn_sign;
                default:   dout = dn_zero;
            endcase
        end

        // R2: a non-circular move toward the MSB leaves the low DIST bits cleared.
        if (en && ctrl.to_msb && ctrl.mode != FILL_WRAP) begin
            p_low_zero_fill_r2: assert (dout[DIST-1:0] == '0)
                else $error("R2 stage %0d low bits not zero", DIST);
        end
        // R3: a zero-fill move toward the LSB leaves the high DIST bits cleared.
        if (en && !ctrl.to_msb && ctrl.mode == FILL_ZERO) begin
            p_high_zero_fill_r3: assert (dout[W-1 -: DIST] == '0)
                else $error("R3 stage %0d high bits not zero", DIST);
        end
        // R4: a sign-fill move keeps the MSB.
        if (en && !ctrl.to_msb && ctrl.mode == FILL_SIGN) begin
            p_sign_kept_r4: assert (dout[W-1] == din[W-1])
                else $error("R4 stage %0d sign lost", DIST);
        end
        // R6: a wrap move never creates or loses ones.
        if (en && ctrl.mode == FILL_WRAP) begin
            p_ones_kept_r6: assert ($countones(dout) == $countones(din))
                else $error("R6 stage %0d popcount changed", DIST);
        end
    end

endmodule

// File: rtl/logshift_unit.sv
`timescale 1ns/1ps
// Module: logshift_unit (top)
// Combinational W-bit shifter built from log2(W) cascaded stages, each driven
// by one bit of the binary shift count. Assumes W is a power of two >= 2.
module logshift_unit
    import logshift_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  logic [AW-1:0] shift_amt,
    input  logic          shift_left,
    input  logic [1:0]    shift_kind,
    output logic [W-1:0]  data_out
);

    localparam int NSTAGE = AW;

    stage_ctrl_t  ctrl;
    logic [W-1:0] chain [NSTAGE+1];

    // Shared control decode for all stages.
    logshift_ctrl u_ctrl (
        .kind   (shift_kind),
        .to_msb (shift_left),
        .ctrl   (ctrl)
    );

    // Entry of the stage chain.
    assign chain[0] = data_in;

    // Stage i moves by 2**i under count bit i (R8).
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        logshift_stage #(
            .W    (W),
            .DIST (1 << i)
        ) u_stage (
            .din  (chain[i]),
            .en   (shift_amt[i]),
            .ctrl (ctrl),
            .dout (chain[i+1])
        );
    end

    // Exit of the stage chain.
    assign data_out = chain[NSTAGE];

endmodule

// File: tb/logshift_unit_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of the shifter against a bit-at-a-time model.
module logshift_unit_tb_top;

    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [AW-1:0] shift_amt = '0;
    logic          shift_left = 1'b0;
    logic [1:0]    shift_kind = 2'b00;
    logic [W-1:0]  data_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    logshift_unit #(.W(W)) dut_i (
        .data_in    (data_in),
        .shift_amt  (shift_amt),
        .shift_left (shift_left),
        .shift_kind (shift_kind),
        .data_out   (data_out)
    );

    // Behavioural model: repeat a one-place move amt times.
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input int amt,
                                           input logic left, input logic [1:0] kind);
        logic [W-1:0] v = d;
        logic         f;
        for (int s = 0; s < amt; s++) begin
            if (left) begin
                f = (kind == 2'b10) ? v[W-1] : 1'b0;
                v = {v[W-2:0], f};
            end else begin
                f = (kind == 2'b10) ? v[0] : (kind == 2'b01) ? v[W-1] : 1'b0;
                v = {f, v[W-1:1]};
            end
        end
        return v;
    endfunction

    function automatic string req_of(input int amt, input logic left, input logic [1:0] kind);
        if (amt == 0)            return "R1";
        if (kind == 2'b10)       return "R6";
        if (kind == 2'b11)       return "R7";
        if (kind == 2'b01)       return left ? "R5" : "R4";
        return left ? "R2" : "R3";
    endfunction

    // Drive inputs after a rising edge, compare at the following falling edge.
    task automatic apply(input logic [W-1:0] d, input int amt, input logic left,
                         input logic [1:0] kind, input logic [W-1:0] exp, input string req);
        @(posedge clk);
        #1;
        data_in    = d;
        shift_amt  = AW'(amt);
        shift_left = left;
        shift_kind = kind;
        @(negedge clk);
        n_tests++;
        if (data_out !== exp) begin
            n_fail++;
            $display("FAIL %s: d=%h amt=%0d left=%0b kind=%0d got %h expected %h",
                     req, d, amt, left, kind, data_out, exp);
        end
    endtask

    // Main stimulus.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle state, zero word with zero count gives zero.
        apply(8'h00, 0, 1'b0, 2'b00, 8'h00, "R1");
        // R8: multi-bit count 7 uses all three stages.
        apply(8'h01, 7, 1'b1, 2'b00, 8'h80, "R8");
        apply(8'h80, 5, 1'b0, 2'b00, 8'h04, "R8");
        // R9: direction flag on a rotate.
        apply(8'h81, 1, 1'b1, 2'b10, 8'h03, "R9");
        apply(8'h81, 1, 1'b0, 2'b10, 8'hC0, "R9");
        // R4: arithmetic right by 7 of a negative word.
        apply(8'h80, 7, 1'b0, 2'b01, 8'hFF, "R4");
        // R5: arithmetic left equals logical left.
        apply(8'hC3, 2, 1'b1, 2'b01, 8'h0C, "R5");
        // R7: reserved kind on a negative word right.
        apply(8'hF0, 4, 1'b0, 2'b11, 8'h0F, "R7");
        // Exhaustive sweep covering R1 to R7 by case.
        for (int k = 0; k < 4; k++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int a = 0; a < W; a++) begin
                    for (int d = 0; d < 256; d++) begin
                        apply(W'(d), a, dir[0], k[1:0],
                              model(W'(d), a, dir[0], k[1:0]),
                              req_of(a, dir[0], k[1:0]));
                    end
                end
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule